// File: doc/BRIEF.md
# Stack and Illegal-Fetch Trap Unit

This block holds the data-memory stack and the program-memory fetch path of a small 8-bit controller. A byte-wide stack pointer addresses a small RAM. The unit serves six request kinds: push or pop a byte, call a target (the unit saves the 15-bit program counter on the stack), return (the unit restores the program counter from the stack), fetch the opcode at the program counter, and load the stack pointer from software. A call also serves as interrupt entry.

No dedicated checker looks for illegal conditions. Unimplemented RAM reads as all ones and unimplemented program memory reads as all zeros. A return with nothing on the stack therefore pops 0xFF twice and sends the program counter to 0x7FFF. The next fetch reads opcode 0x00 there. Opcode 0x00 is the software interrupt, so that fetch raises the trap pulse. Software recovers by loading the stack pointer again.

Control is an enumerated state machine. `ST_IDLE` accepts a request and branches on its kind:
- FETCH goes to `ST_FETCH`.
- PUSH goes to `ST_PUSH`.
- POP goes to `ST_POP`.
- CALL goes to `ST_CALL_HI` and then `ST_CALL_LO`.
- RET goes to `ST_RET_LO` and then `ST_RET_HI`.
- LOAD_SP goes to `ST_LOAD_SP`.

Each final state returns to `ST_IDLE` and raises `done` for one cycle. A request with an unused kind code leaves the machine in `ST_IDLE`.

Top module: `stk_trap_unit`

## Requirements
- R1: While reset is held, and on its release, the stack pointer is 0x2F, the program counter is 0, `trap` and `done` are low and `req_ready` is high.
- R2: PUSH (kind 1) writes `req_byte` at SP, then decrements SP by one. CALL (kind 3) first writes {0, PC[14:8]} at SP and then PC[7:0] at SP-1. It leaves SP two lower and sets PC to `req_target`.
- R3: POP (kind 2) increments SP and returns the byte at the new SP on `pop_byte`. RET (kind 4) reads the low byte from SP+1 and the high byte from SP+2. It sets PC to {high[6:0], low} and leaves SP two higher.
- R4: RAM addresses 0x30 and above read 0xFF. Writes to those addresses have no effect.
- R5: FETCH (kind 0) returns on `opcode` the program word at PC, then increments PC modulo 2^15. A word below 0x4000 is 0x80 | PC[6:0]. A word at or above 0x4000 is 0x00.
- R6: `trap` rises only together with the `done` of a FETCH that returned opcode 0x00, and it lasts exactly one cycle.
- R7: A RET issued straight after reset leaves PC at 0x7FFF and SP at 0x31. The following FETCH raises `trap`.
- R8: LOAD_SP (kind 5) sets SP to `req_byte`, after which push, pop, call and return work from the new value.
- R9: `req_ready` is high only while idle. Each accepted request of kinds 0 to 5 gives exactly one `done` pulse. Kinds 6 and 7 give no `done` and change neither SP nor PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while `req_ready` is high |
| req_kind | input | 3 | 0 FETCH, 1 PUSH, 2 POP, 3 CALL, 4 RET, 5 LOAD_SP |
| req_byte | input | 8 | Byte for PUSH, new SP for LOAD_SP |
| req_target | input | 15 | Call target address |
| req_ready | output | 1 | High in the idle state |
| done | output | 1 | One-cycle completion pulse |
| pop_byte | output | 8 | Byte returned by the last POP |
| sp | output | 8 | Stack pointer |
| pc | output | 15 | Program counter |
| opcode | output | 8 | Word returned by the last FETCH |
| trap | output | 1 | Software-interrupt pulse |

## Verification
The bench drives balanced push/pop pairs to show last-in-first-out order and correct pointer movement. It nests calls at high addresses so that a swapped byte order or a dropped bit 14 shows up. Fetches on both sides of the 0x4000 limit separate implemented words from the zero fill. A return from an empty stack, followed by a fetch, exercises the whole underflow-to-trap path, and a stack pointer reloaded into the unimplemented region shows that those writes are lost. Unused kind codes and back-to-back requests check that the handshake gives exactly one completion per real request.

// File: rtl/stk_trap_pkg.sv
package stk_trap_pkg;
    localparam int DATA_W = 8;
    localparam int PC_W   = 15;

    typedef enum logic [2:0] {
        RK_FETCH   = 3'd0,
        RK_PUSH    = 3'd1,
        RK_POP     = 3'd2,
        RK_CALL    = 3'd3,
        RK_RET     = 3'd4,
        RK_LOAD_SP = 3'd5
    } req_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP,
        ST_CALL_HI,
        ST_CALL_LO,
        ST_RET_LO,
        ST_RET_HI,
        ST_LOAD_SP,
        ST_FETCH
    } st_e;

    // Stand-in program contents: never zero inside the implemented range.
    function automatic logic [DATA_W-1:0] rom_pattern(input logic [PC_W-1:0] a);
        return {1'b1, a[6:0]};
    endfunction
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int W = 8,
    parameter logic [W-1:0] INIT = 8'h2F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dec,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] sp,
    output logic [W-1:0] sp_up
);
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= INIT;
        else if (load) sp <= load_val;
        else if (dec)  sp <= sp - W'(1);
        else if (inc)  sp <= sp + W'(1);
    end

    assign sp_up = sp + W'(1);

    // R2 / R3 / R8: the controller requests at most one pointer change per cycle
    assert_one_sp_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec, inc, load}));
endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
    parameter int W     = 8,
    parameter int AW    = 8,
    parameter int WORDS = 48,
    parameter logic [W-1:0] FILL = 8'hFF
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < WORDS))
            mem[waddr[IW-1:0]] <= wdata;
    end

    always_comb begin
        if (int'(raddr) < WORDS) rdata = mem[raddr[IW-1:0]];
        else                     rdata = FILL;
    end
endmodule

// File: rtl/stk_rom.sv
module stk_rom
    import stk_trap_pkg::*;
#(
    parameter int WORDS = 16384,
    parameter logic [DATA_W-1:0] FILL = 8'h00
) (
    input  logic [PC_W-1:0]   addr,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        if (int'(addr) < WORDS) data = rom_pattern(addr);
        else                    data = FILL;
    end
endmodule

// File: rtl/stk_trap_unit.sv
module stk_trap_unit
    import stk_trap_pkg::*;
#(
    parameter logic [7:0] SP_INIT   = 8'h2F,
    parameter int         RAM_WORDS = 48,
    parameter int         ROM_WORDS = 16384
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [2:0]  req_kind,
    input  logic [7:0]  req_byte,
    input  logic [14:0] req_target,
    output logic        req_ready,
    output logic        done,
    output logic [7:0]  pop_byte,
    output logic [7:0]  sp,
    output logic [14:0] pc,
    output logic [7:0]  opcode,
    output logic        trap
);
    localparam logic [DATA_W-1:0] RAM_FILL = '1;
    localparam logic [DATA_W-1:0] ROM_FILL = '0;

    st_e state, state_nx;

    logic [DATA_W-1:0] byte_q, lo_q;
    logic [PC_W-1:0]   target_q;
    logic              sp_dec, sp_inc, sp_load;
    logic              ram_we;
    logic [DATA_W-1:0] ram_wdata, ram_rdata, rom_data;
    logic [7:0]        sp_up;

    stk_ptr #(.W(8), .INIT(SP_INIT)) u_ptr (
        .clk(clk), .rst_n(rst_n), .dec(sp_dec), .inc(sp_inc), .load(sp_load),
        .load_val(byte_q), .sp(sp), .sp_up(sp_up)
    );

    stk_ram #(.W(DATA_W), .AW(8), .WORDS(RAM_WORDS), .FILL(RAM_FILL)) u_ram (
        .clk(clk), .we(ram_we), .waddr(sp), .wdata(ram_wdata),
        .raddr(sp_up), .rdata(ram_rdata)
    );

    stk_rom #(.WORDS(ROM_WORDS), .FILL(ROM_FILL)) u_rom (
        .addr(pc), .data(rom_data)
    );

    assign req_ready = (state == ST_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    case (req_kind)
                        RK_FETCH:   state_nx = ST_FETCH;
                        RK_PUSH:    state_nx = ST_PUSH;
                        RK_POP:     state_nx = ST_POP;
                        RK_CALL:    state_nx = ST_CALL_HI;
                        RK_RET:     state_nx = ST_RET_LO;
                        RK_LOAD_SP: state_nx = ST_LOAD_SP;
                        default:    state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_CALL_HI: state_nx = ST_CALL_LO;
            ST_RET_LO:  state_nx = ST_RET_HI;
            ST_PUSH, ST_POP, ST_CALL_LO, ST_RET_HI, ST_LOAD_SP, ST_FETCH:
                        state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Stack-side controls per state
    always_comb begin
        ram_we    = 1'b0;
        ram_wdata = byte_q;
        sp_dec    = 1'b0;
        sp_inc    = 1'b0;
        sp_load   = 1'b0;
        unique case (state)
            ST_PUSH:    begin ram_we = 1'b1; sp_dec = 1'b1; end
            ST_CALL_HI: begin ram_we = 1'b1; sp_dec = 1'b1;
                              ram_wdata = DATA_W'(pc >> DATA_W); end
            ST_CALL_LO: begin ram_we = 1'b1; sp_dec = 1'b1;
                              ram_wdata = pc[DATA_W-1:0]; end
            ST_POP, ST_RET_LO, ST_RET_HI: sp_inc = 1'b1;
            ST_LOAD_SP: sp_load = 1'b1;
            default: ;
        endcase
    end

    // Registered outputs and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            done     <= 1'b0;
            trap     <= 1'b0;
            opcode   <= '0;
            pop_byte <= '0;
            lo_q     <= '0;
            byte_q   <= '0;
            target_q <= '0;
        end else begin
            done <= 1'b0;
            trap <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    byte_q   <= req_byte;
                    target_q <= req_target;
                end
                ST_PUSH, ST_LOAD_SP: done <= 1'b1;
                ST_POP: begin pop_byte <= ram_rdata; done <= 1'b1; end
                ST_CALL_HI: ;
                ST_CALL_LO: begin pc <= target_q; done <= 1'b1; end
                ST_RET_LO:  lo_q <= ram_rdata;
                ST_RET_HI: begin
                    pc   <= PC_W'({ram_rdata, lo_q});
                    done <= 1'b1;
                end
                ST_FETCH: begin
                    opcode <= rom_data;
                    trap   <= (rom_data == 8'h00);
                    pc     <= pc + PC_W'(1);
                    done   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    assert_sp_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sp == SP_INIT && pc == '0 && !trap && req_ready));

    assert_sp_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH || state == ST_CALL_HI || state == ST_CALL_LO)
        |=> sp == $past(sp) - 8'd1);

    assert_sp_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POP || state == ST_RET_LO || state == ST_RET_HI)
        |=> sp == $past(sp) + 8'd1);

    assert_trap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (opcode == 8'h00 && done));

    assert_trap_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !trap);

    assert_sp_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LOAD_SP |=> sp == $past(byte_q));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    assert_bad_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind > 3'd5) |=> (req_ready && !done));
endmodule

// File: tb/stk_trap_unit_bench.sv
module stk_trap_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [7:0]  req_byte = 8'd0;
    logic [14:0] req_target = 15'd0;
    logic        req_ready, done, trap;
    logic [7:0]  pop_byte, sp, opcode;
    logic [14:0] pc;

    always #10 clk = ~clk;   // 50 MHz

    stk_trap_unit u_stk_trap_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_byte(req_byte), .req_target(req_target), .req_ready(req_ready),
        .done(done), .pop_byte(pop_byte), .sp(sp), .pc(pc),
        .opcode(opcode), .trap(trap)
    );

    typedef struct {
        string       tag;
        logic [7:0]  e_sp;
        logic [14:0] e_pc;
        logic        chk_byte;
        logic [7:0]  e_byte;
        logic        chk_op;
        logic [7:0]  e_op;
        logic        e_trap;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_fail = 0;

    // Reference model
    logic [7:0]  m_ram [256];
    logic [7:0]  m_sp;
    logic [14:0] m_pc;

    function automatic logic [7:0] m_rd(input logic [7:0] a);
        return (a >= 8'h30) ? 8'hFF : m_ram[a];
    endfunction

    task automatic m_wr(input logic [7:0] a, input logic [7:0] d);
        if (a < 8'h30) m_ram[a] = d;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver: model the request, queue the expectation, then drive it
    task automatic do_op(input string tag, input logic [2:0] k,
                         input logic [7:0] b, input logic [14:0] t);
        exp_t e;
        logic [7:0] lo, hi;
        e.tag = tag; e.chk_byte = 0; e.e_byte = 0; e.chk_op = 0; e.e_op = 0; e.e_trap = 0;
        case (k)
            3'd0: begin
                e.chk_op = 1;
                e.e_op = (m_pc < 15'h4000) ? {1'b1, m_pc[6:0]} : 8'h00;
                e.e_trap = (e.e_op == 8'h00);
                m_pc = m_pc + 15'd1;
            end
            3'd1: begin m_wr(m_sp, b); m_sp = m_sp - 8'd1; end
            3'd2: begin m_sp = m_sp + 8'd1; e.chk_byte = 1; e.e_byte = m_rd(m_sp); end
            3'd3: begin
                m_wr(m_sp, {1'b0, m_pc[14:8]}); m_sp = m_sp - 8'd1;
                m_wr(m_sp, m_pc[7:0]);          m_sp = m_sp - 8'd1;
                m_pc = t;
            end
            3'd4: begin
                m_sp = m_sp + 8'd1; lo = m_rd(m_sp);
                m_sp = m_sp + 8'd1; hi = m_rd(m_sp);
                m_pc = {hi[6:0], lo};
            end
            3'd5: m_sp = b;
            default: ;
        endcase
        e.e_sp = m_sp; e.e_pc = m_pc;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_byte = b; req_target = t;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
    endtask

    // Monitor
    logic trap_prev = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (trap_prev) check("R6 trap lasts one cycle", {31'd0, trap}, 32'd0);
            trap_prev = 1'b0;
            if (rst_n && done) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " sp"}, {24'd0, sp}, {24'd0, e.e_sp});
                    check({e.tag, " pc"}, {17'd0, pc}, {17'd0, e.e_pc});
                    check({e.tag, " R6 trap"}, {31'd0, trap}, {31'd0, e.e_trap});
                    if (e.chk_byte) check({e.tag, " pop_byte"}, {24'd0, pop_byte}, {24'd0, e.e_byte});
                    if (e.chk_op)   check({e.tag, " opcode"}, {24'd0, opcode}, {24'd0, e.e_op});
                    trap_prev = e.e_trap;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        m_sp = 8'h2F; m_pc = 15'd0;
        for (int i = 0; i < 256; i++) m_ram[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state while held
        check("R1 sp in reset", {24'd0, sp}, 32'h2F);
        check("R1 pc in reset", {17'd0, pc}, 32'd0);
        check("R1 trap in reset", {31'd0, trap}, 32'd0);
        check("R1 ready in reset", {31'd0, req_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sp after release", {24'd0, sp}, 32'h2F);
        check("R1 done after release", {31'd0, done}, 32'd0);

        do_op("R5 fetch low", 3'd0, 8'h00, 15'd0);
        do_op("R2 push a", 3'd1, 8'h11, 15'd0);
        do_op("R2 push b", 3'd1, 8'h22, 15'd0);
        do_op("R3 pop b", 3'd2, 8'h00, 15'd0);
        do_op("R3 pop a", 3'd2, 8'h00, 15'd0);
        do_op("R2 call", 3'd3, 8'h00, 15'h0123);
        do_op("R5 fetch in sub", 3'd0, 8'h00, 15'd0);
        do_op("R3 return", 3'd4, 8'h00, 15'd0);
        // R5 limit: last implemented word, then first unimplemented one
        do_op("R2 call near limit", 3'd3, 8'h00, 15'h3FFF);
        do_op("R5 fetch last word", 3'd0, 8'h00, 15'd0);
        do_op("R5 R6 fetch past limit", 3'd0, 8'h00, 15'd0);
        do_op("R3 return from limit", 3'd4, 8'h00, 15'd0);
        // R7: underflow path
        do_op("R7 return on empty stack", 3'd4, 8'h00, 15'd0);
        do_op("R7 fetch at 7FFF traps", 3'd0, 8'h00, 15'd0);
        // R8: recovery
        do_op("R8 reload sp", 3'd5, 8'h2F, 15'd0);
        do_op("R8 push after reload", 3'd1, 8'h5A, 15'd0);
        do_op("R8 pop after reload", 3'd2, 8'h00, 15'd0);
        // R4: writes into the unimplemented region are lost
        do_op("R4 sp into fill region", 3'd5, 8'h35, 15'd0);
        do_op("R4 push ignored", 3'd1, 8'h12, 15'd0);
        do_op("R4 pop reads FF", 3'd2, 8'h00, 15'd0);
        // R2/R3 nesting at high addresses
        do_op("R8 sp mid", 3'd5, 8'h20, 15'd0);
        do_op("R2 call high", 3'd3, 8'h00, 15'h7654);
        do_op("R2 nested call", 3'd3, 8'h00, 15'h0010);
        do_op("R5 fetch nested", 3'd0, 8'h00, 15'd0);
        do_op("R3 nested return", 3'd4, 8'h00, 15'd0);
        do_op("R3 outer return", 3'd4, 8'h00, 15'd0);

        // R9: unused kinds give no done and change nothing
        for (int k = 6; k < 8; k++) begin
            @(negedge clk);
            req_valid = 1'b1; req_kind = 3'(k);
            @(negedge clk);
            req_valid = 1'b0;
            repeat (3) @(negedge clk);
            check("R9 unused kind sp", {24'd0, sp}, {24'd0, m_sp});
            check("R9 unused kind pc", {17'd0, pc}, {17'd0, m_pc});
            check("R9 ready after unused kind", {31'd0, req_ready}, 32'd1);
        end
        do_op("R9 push after unused", 3'd1, 8'h77, 15'd0);
        do_op("R9 pop after unused", 3'd2, 8'h00, 15'd0);

        repeat (4) @(negedge clk);
        check("R9 all done pulses seen", exp_q.size(), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule